// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block produces the address of the next microinstruction for a microprogrammed control unit. It keeps a microinstruction address register that drives the control store's address input. Every clock it loads that register from one of four places: the current address plus one, an address field carried by the current microinstruction, an address mapped from the opcode bits of the macro-instruction being run, or a single link register that holds the return point of a microsubroutine.

The control store word feeds three fields back into the sequencer: a condition selector, a two-bit branch kind and a target address. The datapath supplies status flags, and the instruction register supplies the opcode. A jump or call can be made to depend on one of the status flags. When that flag is low, the sequencer steps to the next address in order. A taken call stores the address after the call in the link register. A return then loads that stored address back.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst` is high at a rising clock edge, `uaddr` and the link register are both loaded with 0.
- R2: With `br_kind` = 2'b00 (jump) and a true condition, `uaddr` takes `br_addr` on the next edge.
- R3: A jump or a call (`br_kind` = 2'b01) whose condition is false loads `uaddr + 1` on the next edge.
- R4: `cond_sel` = 2'b00 makes the condition true whatever the value of `status`.
- R5: `cond_sel` values 2'b01, 2'b10 and 2'b11 make the condition equal to `status[0]`, `status[1]` and `status[2]`.
- R6: A call with a true condition loads `br_addr` into `uaddr` and stores the old `uaddr + 1` in the link register.
- R7: A call with a false condition leaves the link register unchanged.
- R8: With `br_kind` = 2'b10 (return), `uaddr` takes the link register value. The condition does not affect it.
- R9: With `br_kind` = 2'b11 (map), `uaddr` takes {1'b0, opcode[3:0], 2'b00}. The condition does not affect it.
- R10: The incremented address wraps from 127 to 0, both for sequential stepping and for the return point that a call saves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_sel | input | 2 | Condition selector from the microinstruction |
| br_kind | input | 2 | Branch kind: 00 jump, 01 call, 10 return, 11 map |
| br_addr | input | 7 | Target address field from the microinstruction |
| opcode | input | 4 | Macro-instruction opcode bits |
| status | input | 3 | Status flags tested by conditional branches |
| uaddr | output | 7 | Registered microinstruction address |

## Verification
The bench runs every condition selector against status patterns in which the selected flag disagrees with its neighbours. A selector wired to the wrong flag would then take or skip a branch where it should not. It makes a call with a false condition and then a return. A design that updated the link register on an untaken call would return to the wrong place. It issues return and map words with a false condition to catch a design that gates them on the condition. It also makes a call from address 127, so the saved return point must wrap to 0. The map tests use opcodes 0, 10 and 15 to expose a shifted or misplaced opcode field.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    BK_JUMP = 2'b00,
    BK_CALL = 2'b01,
    BK_RET  = 2'b10,
    BK_MAP  = 2'b11
  } br_kind_e;
endpackage

// File: rtl/useq_cond_pick.sv
module useq_cond_pick #(
  parameter int NSTAT = 3,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NSTAT-1:0] status,
  output logic             pass
);
  logic [NSTAT:0] hit;

  // selector zero is the unconditional case
  assign hit[0] = (sel == '0);

  for (genvar g = 0; g < NSTAT; g++) begin : g_flag
    assign hit[g+1] = (sel == SEL_W'(g + 1)) & status[g];
  end

  assign pass = |hit;
endmodule

// File: rtl/useq_opc_map.sv
module useq_opc_map #(
  parameter int OPC_W     = 4,
  parameter int ADDR_W    = 7,
  parameter int MAP_SHIFT = 2
) (
  input  logic [OPC_W-1:0]  opc,
  output logic [ADDR_W-1:0] mapped
);
  localparam int PAD_W = ADDR_W - OPC_W - MAP_SHIFT;

  if (PAD_W > 0) begin : g_pad
    if (MAP_SHIFT > 0) begin : g_lo
      assign mapped = {{PAD_W{1'b0}}, opc, {MAP_SHIFT{1'b0}}};
    end else begin : g_nolo
      assign mapped = {{PAD_W{1'b0}}, opc};
    end
  end else begin : g_nopad
    if (MAP_SHIFT > 0) begin : g_lo
      assign mapped = {opc, {MAP_SHIFT{1'b0}}};
    end else begin : g_nolo
      assign mapped = opc;
    end
  end
endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
  import useq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  br_kind_e          kind,
  input  logic              pass,
  input  logic [ADDR_W-1:0] inc,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] mapped,
  input  logic [ADDR_W-1:0] link,
  output logic [ADDR_W-1:0] nxt,
  output logic              save_link
);
  always_comb begin
    nxt       = inc;
    save_link = 1'b0;
    unique case (kind)
      BK_JUMP: nxt = pass ? target : inc;
      BK_CALL: begin
        nxt       = pass ? target : inc;
        save_link = pass;
      end
      BK_RET:  nxt = link;
      BK_MAP:  nxt = mapped;
      default: nxt = inc;
    endcase
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int OPC_W     = 4,
  parameter int NSTAT     = 3,
  parameter int SEL_W     = 2,
  parameter int MAP_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic [1:0]        br_kind,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [NSTAT-1:0]  status,
  output logic [ADDR_W-1:0] uaddr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  br_kind_e          kind;
  logic              cond_pass;
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] mapped;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] link_q;
  logic              save_link;

  assign kind = br_kind_e'(br_kind);
  assign inc  = uaddr + STEP;

  useq_cond_pick #(.NSTAT(NSTAT), .SEL_W(SEL_W)) u_cond (
    .sel    (cond_sel),
    .status (status),
    .pass   (cond_pass)
  );

  useq_opc_map #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .MAP_SHIFT(MAP_SHIFT)) u_map (
    .opc    (opcode),
    .mapped (mapped)
  );

  useq_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
    .kind      (kind),
    .pass      (cond_pass),
    .inc       (inc),
    .target    (br_addr),
    .mapped    (mapped),
    .link      (link_q),
    .nxt       (nxt),
    .save_link (save_link)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      uaddr  <= '0;
      link_q <= '0;
    end else begin
      uaddr <= nxt;
      if (save_link) link_q <= inc;
    end
  end
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int ADDR_W    = 7,
  parameter int OPC_W     = 4,
  parameter int MAP_SHIFT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        br_kind,
  input logic [ADDR_W-1:0] br_addr,
  input logic [OPC_W-1:0]  opcode,
  input logic [ADDR_W-1:0] uaddr,
  input logic [ADDR_W-1:0] link_q,
  input logic              cond_pass
);
  typedef logic [ADDR_W-1:0] addr_t;

  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_kind) == 2'b00 && $past(cond_pass)) |-> uaddr == $past(br_addr)); // R2

  AST_BRANCH_FALL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(br_kind[1]) && !$past(cond_pass)) |-> uaddr == addr_t'($past(uaddr) + 1'b1)); // R3

  AST_CALL_SAVE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_kind) == 2'b01 && $past(cond_pass)) |-> (link_q == addr_t'($past(uaddr) + 1'b1) && uaddr == $past(br_addr))); // R6

  AST_CALL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_kind) == 2'b01 && !$past(cond_pass)) |-> link_q == $past(link_q)); // R7

  AST_RETURN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_kind) == 2'b10) |-> uaddr == $past(link_q)); // R8

  AST_MAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_kind) == 2'b11) |-> uaddr == addr_t'(addr_t'($past(opcode)) << MAP_SHIFT)); // R9
endmodule

bind useq_next_addr useq_next_addr_chk #(
  .ADDR_W(ADDR_W), .OPC_W(OPC_W), .MAP_SHIFT(MAP_SHIFT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .br_kind   (br_kind),
  .br_addr   (br_addr),
  .opcode    (opcode),
  .uaddr     (uaddr),
  .link_q    (link_q),
  .cond_pass (cond_pass)
);

// File: tb/sim_useq_next_addr.sv
`timescale 1ns/1ps
module sim_useq_next_addr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cond_sel = '0;
  logic [1:0] br_kind = '0;
  logic [6:0] br_addr = '0;
  logic [3:0] opcode = '0;
  logic [2:0] status = '0;
  logic [6:0] uaddr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  useq_next_addr u0 (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_kind(br_kind),
    .br_addr(br_addr), .opcode(opcode), .status(status), .uaddr(uaddr)
  );

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: uaddr=%0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one microinstruction word away from the edge, sample after it
  task automatic step(input logic [1:0] k, input logic [1:0] s, input logic [6:0] a,
                      input logic [3:0] o, input logic [2:0] st);
    @(negedge clk);
    br_kind = k; cond_sel = s; br_addr = a; opcode = o; status = st;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(2'b00, 2'b00, 7'h44, 4'h0, 3'b000);
    step(2'b00, 2'b00, 7'h44, 4'h0, 3'b000);
    check("R1 reset", uaddr, 7'h00);
    rst = 1'b0;
  endtask

  task automatic t_jump();
    step(2'b00, 2'b00, 7'h55, 4'h0, 3'b000);
    check("R2/R4 jump sel0 status 000", uaddr, 7'h55);
    step(2'b00, 2'b00, 7'h12, 4'h0, 3'b111);
    check("R4 jump sel0 status 111", uaddr, 7'h12);
    step(2'b00, 2'b01, 7'h10, 4'h0, 3'b110);
    check("R3/R5 sel1 flag0 low", uaddr, 7'h13);
    step(2'b00, 2'b10, 7'h20, 4'h0, 3'b010);
    check("R5 sel2 flag1 high", uaddr, 7'h20);
    step(2'b00, 2'b10, 7'h30, 4'h0, 3'b101);
    check("R3/R5 sel2 flag1 low", uaddr, 7'h21);
    step(2'b00, 2'b11, 7'h30, 4'h0, 3'b011);
    check("R3/R5 sel3 flag2 low", uaddr, 7'h22);
    step(2'b00, 2'b11, 7'h33, 4'h0, 3'b100);
    check("R5 sel3 flag2 high", uaddr, 7'h33);
    step(2'b00, 2'b01, 7'h05, 4'h0, 3'b001);
    check("R5 sel1 flag0 high", uaddr, 7'h05);
  endtask

  task automatic t_call_ret();
    step(2'b00, 2'b00, 7'h30, 4'h0, 3'b000);
    step(2'b01, 2'b00, 7'h40, 4'h0, 3'b000);
    check("R6 call taken", uaddr, 7'h40);
    step(2'b01, 2'b01, 7'h50, 4'h0, 3'b110);
    check("R3/R7 call not taken", uaddr, 7'h41);
    step(2'b10, 2'b01, 7'h66, 4'h0, 3'b000);
    check("R6/R7/R8 return after untaken call", uaddr, 7'h31);
    step(2'b00, 2'b00, 7'h08, 4'h0, 3'b000);
    step(2'b10, 2'b00, 7'h66, 4'h0, 3'b111);
    check("R8 second return same link", uaddr, 7'h31);
  endtask

  task automatic t_map();
    step(2'b11, 2'b01, 7'h7f, 4'hA, 3'b000);
    check("R9 map opcode A cond false", uaddr, 7'h28);
    step(2'b11, 2'b00, 7'h00, 4'hF, 3'b000);
    check("R9 map opcode F", uaddr, 7'h3C);
    step(2'b11, 2'b11, 7'h11, 4'h0, 3'b111);
    check("R9 map opcode 0", uaddr, 7'h00);
  endtask

  task automatic t_wrap();
    step(2'b00, 2'b00, 7'h7f, 4'h0, 3'b000);
    check("R2 jump to top", uaddr, 7'h7f);
    step(2'b00, 2'b01, 7'h22, 4'h0, 3'b000);
    check("R10 step wraps", uaddr, 7'h00);
    step(2'b00, 2'b00, 7'h7f, 4'h0, 3'b000);
    step(2'b01, 2'b00, 7'h10, 4'h0, 3'b000);
    check("R6 call from top", uaddr, 7'h10);
    step(2'b10, 2'b00, 7'h55, 4'h0, 3'b000);
    check("R10 saved return wraps", uaddr, 7'h00);
  endtask

  task automatic t_reset_mid();
    step(2'b00, 2'b00, 7'h2a, 4'h0, 3'b000);
    rst = 1'b1;
    step(2'b00, 2'b00, 7'h2b, 4'h0, 3'b000);
    check("R1 reset during run", uaddr, 7'h00);
    rst = 1'b0;
    step(2'b10, 2'b00, 7'h2b, 4'h0, 3'b000);
    check("R1 link cleared by reset", uaddr, 7'h00);
  endtask

  initial begin
    t_reset();
    t_jump();
    t_call_ret();
    t_map();
    t_wrap();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule